// File: doc/BRIEF.md
# GPIO Line Interrupt Aggregator

This block is the interrupt front end of a 32-line general-purpose I/O port. Each cycle it receives the raw input vector of the port and a per-line polarity vector. XOR-ing the two gives the sensed value of each line. A line with polarity 0 senses a high level or a rising edge. A line with polarity 1 senses a low level or a falling edge.

Each line can request an interrupt in two ways. A level request is the sensed bit gated by a level-enable bit, with nothing stored. An edge request comes from a sticky cause bit, gated by an edge-enable bit. The cause bit is set whenever the sensed bit goes from 0 to 1. Cause bits are set even while the line is disabled. Software clears them by writing 0 to them.

The per-line requests are reduced to one summary interrupt per group of eight consecutive lines. Software reaches the cause register and the two enable registers through a simple single-cycle write port and a combinational read port. The two enable registers are moved away from their nominal addresses by a parameter.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset the cause register, the edge-enable register and the level-enable register all read 0, and every summary output is 0.
- R2: The cause register is at byte address 0x14. The edge-enable register is at 0x18 + MASK_SHIFT, and the level-enable register is at 0x1C + MASK_SHIFT. Bit i of each register belongs to line i. Reads of any other address return 0, and writes to any other address change no register.
- R3: When the sensed bit of a line goes from 0 to 1 between two consecutive clock edges, its cause bit is set on the second edge. No edge is detected at the first clock edge after reset is released.
- R4: The sensed value is line_in XOR polarity. With polarity 1, a falling input sets the cause bit and a rising input does not.
- R5: A write to the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: If a new edge on a line arrives on the same clock edge as a write that clears that line's cause bit, the bit ends up set.
- R7: Cause bits are set even when the edge-enable bit is 0. Setting the edge-enable bit of a line that has a pending cause raises its group output in the cycle after the write.
- R8: A line's level request is its sensed bit AND its level-enable bit, with nothing stored. The request follows the input in the same cycle and disappears when the input returns.
- R9: Summary output g is the OR of the level and edge requests of lines 8g to 8g+7.
- R10: Writing 0 to the cause register and to both enable registers leaves every summary output at 0 while the registers stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 32 | Raw input level of each line |
| polarity | input | 32 | Per-line inversion applied before sensing |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| grp_irq | output | 4 | One summary interrupt per group of eight lines |

## Verification
The case that needs care is an edge on a line landing on the same clock edge as a software write that clears that line's cause bit. The bench builds this case on purpose. It holds a line low, then raises it in the very cycle in which it writes all zeros to the cause register. It then checks that the bit reads back as set. The random phase also produces such collisions, together with partial clears, and compares every cycle against a reference model. In that model, the new edge is applied after the clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CAUSE = 2'd1,
      SEL_EMASK = 2'd2,
      SEL_LMASK = 2'd3
   } reg_sel_e;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/gpio_irq_edge_det.sv
module gpio_irq_edge_det #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sense,
   output logic [WIDTH-1:0] edge_hit
);

   logic [WIDTH-1:0] sense_q;
   logic             armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         armed_q <= 1'b0;
      end else begin
         sense_q <= sense;
         armed_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      assign edge_hit[i] = armed_q & sense[i] & ~sense_q[i];
   end

   AST_NO_EDGE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> (sense_q == $past(sense))) else $error("sense history lost"); // R3

endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] edge_hit,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] keep_bits,
   output logic [WIDTH-1:0] cause
);

   logic [WIDTH-1:0] kept;

   always_comb begin
      kept = cause;
      if (clr_we) kept = cause & keep_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause <= '0;
      else        cause <= kept | edge_hit;
   end

   AST_EDGE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit != '0) |=> ((cause & $past(edge_hit)) == $past(edge_hit))) else $error("edge lost"); // R6
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & ~$past(cause) & ~$past(edge_hit)) == '0)) else $error("cause set w/o edge"); // R3
   AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((cause & $past(cause & keep_bits)) == $past(cause & keep_bits))) else $error("kept bit cleared"); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && edge_hit == '0) |=> $stable(cause)) else $error("cause moved"); // R5

endmodule

// File: rtl/gpio_irq_mask_regs.sv
module gpio_irq_mask_regs #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             em_we,
   input  logic             lm_we,
   input  logic [WIDTH-1:0] wr_val,
   output logic [WIDTH-1:0] edge_en,
   output logic [WIDTH-1:0] level_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     edge_en <= '0;
      else if (em_we) edge_en <= wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     level_en <= '0;
      else if (lm_we) level_en <= wr_val;
   end

   AST_EMASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      em_we |=> (edge_en == $past(wr_val))) else $error("edge enable load"); // R2
   AST_LMASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lm_we |=> $stable(level_en)) else $error("level enable moved"); // R2

endmodule

// File: rtl/gpio_irq_group_or.sv
module gpio_irq_group_or #(
   parameter int unsigned WIDTH      = 32,
   parameter int unsigned GROUP_SIZE = 8,
   localparam int unsigned NGROUPS   = WIDTH / GROUP_SIZE
) (
   input  logic [WIDTH-1:0]   req,
   output logic [NGROUPS-1:0] grp
);

   for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
      if (GROUP_SIZE == 1) begin : g_single
         assign grp[g] = req[g];
      end else begin : g_multi
         assign grp[g] = |req[g*GROUP_SIZE +: GROUP_SIZE];
      end
   end

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned GROUP_SIZE = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CAUSE_OFS  = 'h14,
   parameter int unsigned EMASK_OFS  = 'h18,
   parameter int unsigned LMASK_OFS  = 'h1C,
   parameter int unsigned MASK_SHIFT = 0,
   localparam int unsigned NGROUPS   = NUM_LINES / GROUP_SIZE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   input  logic [NUM_LINES-1:0] polarity,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data,
   output logic [NGROUPS-1:0]   grp_irq
);

   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_OFS);
   localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(EMASK_OFS + MASK_SHIFT);
   localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(LMASK_OFS + MASK_SHIFT);
   localparam int unsigned GRP_IDX_W = clog2_min1(NGROUPS);

   if (NUM_LINES % GROUP_SIZE != 0) begin : g_bad_group
      $error("NUM_LINES must be a multiple of GROUP_SIZE");
   end
   if (DATA_W < NUM_LINES) begin : g_bad_width
      $error("DATA_W must cover NUM_LINES");
   end
   if (A_CAUSE == A_EMASK || A_CAUSE == A_LMASK || A_EMASK == A_LMASK) begin : g_bad_map
      $error("register addresses collide");
   end
   if ((EMASK_OFS + MASK_SHIFT) >= (1 << ADDR_W) || (LMASK_OFS + MASK_SHIFT) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register address exceeds ADDR_W");
   end
   if (GRP_IDX_W > 16) begin : g_bad_groups
      $error("too many groups");
   end

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == A_CAUSE)      return SEL_CAUSE;
      else if (a == A_EMASK) return SEL_EMASK;
      else if (a == A_LMASK) return SEL_LMASK;
      else                   return SEL_NONE;
   endfunction

   reg_sel_e wr_sel, rd_sel;
   logic [NUM_LINES-1:0] sense, edge_hit, cause, edge_en, level_en, req;
   logic [NUM_LINES-1:0] wr_val;

   assign wr_sel = wr_en ? decode(wr_addr) : SEL_NONE;
   assign rd_sel = decode(rd_addr);
   assign wr_val = wr_data[NUM_LINES-1:0];
   assign sense  = line_in ^ polarity;

   gpio_irq_edge_det #(.WIDTH(NUM_LINES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sense    (sense),
      .edge_hit (edge_hit)
   );

   gpio_irq_cause #(.WIDTH(NUM_LINES)) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_hit  (edge_hit),
      .clr_we    (wr_sel == SEL_CAUSE),
      .keep_bits (wr_val),
      .cause     (cause)
   );

   gpio_irq_mask_regs #(.WIDTH(NUM_LINES)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .em_we    (wr_sel == SEL_EMASK),
      .lm_we    (wr_sel == SEL_LMASK),
      .wr_val   (wr_val),
      .edge_en  (edge_en),
      .level_en (level_en)
   );

   assign req = (sense & level_en) | (cause & edge_en);

   gpio_irq_group_or #(.WIDTH(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_grp (
      .req (req),
      .grp (grp_irq)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_CAUSE: rd_data[NUM_LINES-1:0] = cause;
         SEL_EMASK: rd_data[NUM_LINES-1:0] = edge_en;
         SEL_LMASK: rd_data[NUM_LINES-1:0] = level_en;
         default:   rd_data = '0;
      endcase
   end

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en == '0 && level_en == '0) |-> (grp_irq == '0)) else $error("irq while all disabled"); // R10
   AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_NONE) |=> ($stable(edge_en) && $stable(level_en))) else $error("stray write"); // R2

endmodule

// File: tb/gpio_irq_agg_tb_top.sv
module gpio_irq_agg_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] AC = 8'h14;
   localparam logic [7:0] AE = 8'h38;
   localparam logic [7:0] AL = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] line_in = '0, polarity = '0, wr_data = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] rd_data;
   logic [3:0]  grp_irq;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // reference state
   bit [31:0] m_cause, m_em, m_lm, m_prev;
   bit        m_armed;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_agg #(.MASK_SHIFT(32'h20)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .polarity(polarity),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .grp_irq(grp_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit [31:0] m_read(input logic [7:0] a);
      if (a == AC) return m_cause;
      if (a == AE) return m_em;
      if (a == AL) return m_lm;
      return 0;
   endfunction

   function automatic bit [3:0] m_grp();
      bit [3:0] r = 0;
      for (int ln = 0; ln < 32; ln++) begin
         bit s = line_in[ln] ^ polarity[ln];
         if ((s && m_lm[ln]) || (m_cause[ln] && m_em[ln])) r[ln / 8] = 1'b1;
      end
      return r;
   endfunction

   task automatic tick(input logic [31:0] li, input logic [31:0] po, input bit we,
                       input logic [7:0] wa, input logic [31:0] wd, input logic [7:0] ra);
      bit [31:0] nc, s;
      line_in = li; polarity = po; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      #1;
      chk("R9 summary vs model", {28'd0, grp_irq}, {28'd0, m_grp()});
      chk("R2 read vs model", rd_data, m_read(ra));
      s  = li ^ po;
      nc = m_cause;
      if (we && wa == AC) nc = nc & wd;
      for (int ln = 0; ln < 32; ln++)
         if (m_armed && s[ln] && !m_prev[ln]) nc[ln] = 1'b1;
      @(posedge clk);
      m_cause = nc;
      if (we && wa == AE) m_em = wd;
      if (we && wa == AL) m_lm = wd;
      m_prev = s; m_armed = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input logic [31:0] li, input logic [31:0] po);
      tick(li, po, 1'b0, 8'h00, 32'h0, AC);
   endtask

   task automatic wr(input logic [31:0] li, input logic [31:0] po, input logic [7:0] a, input logic [31:0] d);
      tick(li, po, 1'b1, a, d, AC);
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic do_reset(input logic [31:0] li);
      rst_n = 1'b0; wr_en = 1'b0; line_in = li; polarity = '0;
      m_cause = 0; m_em = 0; m_lm = 0; m_prev = 0; m_armed = 0;
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      do_reset('0);
      // R1 reset state
      peek(AC, v); chk("R1 cause after reset", v, 0);
      peek(AE, v); chk("R1 edge enable after reset", v, 0);
      peek(AL, v); chk("R1 level enable after reset", v, 0);
      chk("R1 outputs after reset", {28'd0, grp_irq}, 0);
      // R2 unshifted addresses unmapped
      wr(0, 0, 8'h18, 32'hFFFF_FFFF);
      wr(0, 0, 8'h1C, 32'hFFFF_FFFF);
      peek(AE, v); chk("R2 stray write edge enable", v, 0);
      peek(AL, v); chk("R2 stray write level enable", v, 0);
      peek(8'h18, v); chk("R2 unmapped read", v, 0);
      // R3 rising edge latched, R7 latched while disabled
      idle(0, 0); idle(32'h8, 0);
      peek(AC, v); chk("R3 edge sets cause", v, 32'h8);
      chk("R7 masked cause no irq", {28'd0, grp_irq}, 0);
      wr(32'h8, 0, AE, 32'h8);
      chk("R7 unmask raises irq", {28'd0, grp_irq}, 4'b0001);
      // R5 clear semantics
      idle(32'h208, 0);
      wr(32'h208, 0, AC, ~32'h200);
      peek(AC, v); chk("R5 write zero clears, one keeps", v, 32'h8);
      wr(32'h208, 0, AC, 32'h0);
      peek(AC, v); chk("R5 clear all", v, 0);
      chk("R5 irq drops after clear", {28'd0, grp_irq}, 0);
      // R6 edge beats clear
      wr(32'h228, 0, AC, 32'h0);
      peek(AC, v); chk("R6 edge wins over clear", v, 32'h20);
      wr(32'h228, 0, AC, 32'h0);
      // R4 polarity
      idle(32'h1000, 32'h1000); idle(32'h1000, 32'h1000);
      idle(0, 32'h1000);
      peek(AC, v); chk("R4 falling edge with polarity 1", v, 32'h1000);
      wr(0, 32'h1000, AC, 0);
      idle(32'h1000, 32'h1000);
      peek(AC, v); chk("R4 rising ignored with polarity 1", v, 0);
      // R8 level not latched
      wr(0, 0, AL, 32'h0010_0000);
      idle(32'h0010_0000, 0);
      chk("R8 level request follows input", {28'd0, grp_irq}, 4'b0100);
      idle(0, 0);
      chk("R8 level request not stored", {28'd0, grp_irq}, 0);
      // R9 grouping
      wr(0, 0, AL, 32'h8100_0080);
      idle(32'h8000_0000, 0); chk("R9 line 31 to group 3", {28'd0, grp_irq}, 4'b1000);
      idle(32'h0100_0000, 0); chk("R9 line 24 to group 3", {28'd0, grp_irq}, 4'b1000);
      idle(32'h0000_0080, 0); chk("R9 line 7 to group 0", {28'd0, grp_irq}, 4'b0001);
      idle(32'h8000_0080, 0); chk("R9 two groups", {28'd0, grp_irq}, 4'b1001);
      // R10 zero writes quiet everything
      wr(0, 0, AE, 32'hFFFF_FFFF);
      wr(0, 0, AC, 0); wr(0, 0, AE, 0); wr(0, 0, AL, 0);
      idle(32'h5555_AAAA, 0);
      chk("R10 all quiet", {28'd0, grp_irq}, 0);
      peek(AE, v); chk("R10 edge enable zero", v, 0);
      // R3 no edge at first clock after reset
      do_reset(32'hFFFF_FFFF);
      idle(32'hFFFF_FFFF, 0);
      peek(AC, v); chk("R3 no edge after reset", v, 0);
      // random phase, compared against the model every clock
      for (int k = 0; k < 3000; k++) begin
         logic [7:0] a;
         int sel;
         sel = $urandom_range(0, 9);
         a = (sel < 3) ? AC : (sel < 5) ? AE : (sel < 7) ? AL : 8'h10;
         tick($urandom & $urandom, (k % 64 < 32) ? 32'h0 : $urandom,
              ($urandom_range(0, 3) == 0), a, $urandom | $urandom,
              (k % 3 == 0) ? AC : (k % 3 == 1) ? AE : AL);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule